// File: doc/BRIEF.md
# Serial Interface Status Flag Unit

This block keeps the eight status flags of a serial controller that runs either as a two-wire (I2C) bus port or as a clock-synchronous shift port. The shift engine next to it reports events as single-cycle pulses: SCL rising edges with the bit number inside the frame, the level sampled on SDA and the level the controller drives, start and stop detection, the slave address and general call compare results, and the transfer points of the transmit and receive data registers. The block turns these events into sticky flags and presents them as one 8-bit status word.

Software reads the status word and clears a flag by writing 0 to it, but only after a read has returned that flag as 1. Writing 1 leaves a flag alone. Two data register accesses also clear flags: a write of transmit data clears transmit-empty and transmit-end, and a read of receive data clears receive-full. Bit 2 has two meanings. In I2C mode it reports lost arbitration. In synchronous mode it reports a receive overrun. When acknowledge checking is on, a raised no-acknowledge flag drives a halt output to the shift engine.

Top module: `sif_status_unit`

## Requirements
- R1: After reset every flag reads 0. Status bit positions: 0 general call, 1 address match, 2 arbitration lost / overrun, 3 stop seen, 4 no acknowledge, 5 receive full, 6 transmit end, 7 transmit empty.
- R2: A status write with 1 in a bit position leaves that flag unchanged.
- R3: A status write with 0 in a bit position clears that flag only if a status read since the last status write returned it as 1. Any status write discards all read qualifications.
- R4: When a set event and a clearing access hit the same flag in the same cycle, the flag ends up 1.
- R5: In I2C master transmit mode, bit 2 sets on an SCL rising edge where the driven SDA differs from the SDA pin. In I2C master mode it also sets when a start is detected while the SDA pin is high.
- R6: In synchronous mode, bit 2 sets when the last bit of a frame is received while receive-full is 1. In I2C mode that event does not set it.
- R7: Transmit-end sets in I2C mode on the SCL rising edge with bit number 9 if transmit-empty is 1. In synchronous mode it sets on the last transmitted bit.
- R8: Transmit-empty sets when transmit data is loaded into the shift register, when transmit mode is selected, when a start is generated, or on a switch from slave receive to slave transmit.
- R9: A transmit data write clears bits 7 and 6. A receive data read clears bit 5.
- R10: In I2C transmit mode with acknowledge checking on, an SDA pin level of 1 at the SCL rising edge with bit number 9 sets no-acknowledge and raises halt. With checking off, no-acknowledge does not set.
- R11: In I2C slave receive mode, an address match or general call compare pulse sets bit 1 or bit 0, but only during the first frame after a start.
- R12: In I2C mode a detected stop sets bit 3 only if a complete frame has passed since the last start or stop.
- R13: Receive-full sets in the cycle the receive data register is loaded from the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i2c | input | 1 | 1: I2C bus mode, 0: clock-synchronous mode |
| mode_master | input | 1 | 1: master |
| mode_tx | input | 1 | 1: transmit direction |
| ack_chk_en | input | 1 | Acknowledge checking enable |
| scl_rise | input | 1 | SCL rising edge pulse |
| bit_num | input | 4 | Bit number within the frame at this SCL edge (1 to 9) |
| sda_pin | input | 1 | Sampled SDA pin level |
| sda_drv | input | 1 | SDA level the controller drives |
| start_det | input | 1 | Start condition detected |
| stop_det | input | 1 | Stop condition detected |
| addr_hit | input | 1 | Received frame equals own slave address |
| gcall_hit | input | 1 | Received frame is the general call address |
| tx_load | input | 1 | Transmit data moved into the shift register |
| tx_mode_sel | input | 1 | Transmit mode selected |
| start_gen | input | 1 | Start or repeated start generated |
| slv_to_tx | input | 1 | Switch from slave receive to slave transmit |
| sync_tx_last | input | 1 | Synchronous mode: last bit shifted out |
| sync_rx_last | input | 1 | Synchronous mode: last bit received |
| rx_copy | input | 1 | Shift register copied into receive data register |
| st_rd | input | 1 | Status register read strobe |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status register write data |
| rdr_rd | input | 1 | Receive data register read strobe |
| tdr_wr | input | 1 | Transmit data register write strobe |
| st_rdata | output | 8 | Status word |
| xfer_halt | output | 1 | Halt request after no-acknowledge |

## Verification
The embedded assertions check on every cycle that a 1 written to a flag never changes it, that no flag falls without a qualifying read or a side-effect clear, that a set event always wins, and that data register accesses clear their flags. The event decoding is shown only by the bench scenarios: the I2C/synchronous meaning of bit 2, the ninth-edge conditions for transmit-end and no-acknowledge, the first-frame window for address matches, and the frame condition for stop. A behavioural model in the bench follows every cycle of these scenarios and is compared with the status word at each clock.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int NFLAG = 8;

  // Status bit positions (software decodes these)
  localparam int B_GCALL  = 0;
  localparam int B_ADDR   = 1;
  localparam int B_ARBOVR = 2;
  localparam int B_STOP   = 3;
  localparam int B_NACK   = 4;
  localparam int B_RXFULL = 5;
  localparam int B_TXEND  = 6;
  localparam int B_TXEMP  = 7;

  typedef struct packed {
    logic i2c;
    logic master;
    logic tx;
    logic ack_chk;
  } sif_mode_t;
endpackage

// File: rtl/sif_rst_sync.sv
module sif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sif_frame_track.sv
module sif_frame_track #(
  parameter int CNT_W    = 4,
  parameter int ACK_EDGE = 9
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             i2c,
  input  logic             scl_rise,
  input  logic [CNT_W-1:0] bit_num,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sync_tx_last,
  input  logic             sync_rx_last,
  output logic             frame_end,
  output logic             first_frame,
  output logic             frame_done
);
  localparam logic [CNT_W-1:0] ACK_NUM = CNT_W'(ACK_EDGE);

  logic first_q, first_d;
  logic done_q, done_d;

  always_comb begin
    frame_end = i2c && scl_rise && (bit_num == ACK_NUM);

    first_d = first_q;
    if (start_det)      first_d = 1'b1;
    else if (frame_end) first_d = 1'b0;

    done_d = done_q;
    if (start_det || stop_det)                           done_d = 1'b0;
    else if (frame_end || sync_tx_last || sync_rx_last) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign first_frame = first_q;
  assign frame_done  = done_q;

  AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_ni)
    start_det |=> (first_frame && !frame_done)); // R11
endmodule

// File: rtl/sif_event_decode.sv
module sif_event_decode
  import sif_pkg::*;
(
  input  sif_mode_t        mode,
  input  logic             scl_rise,
  input  logic             frame_end,
  input  logic             first_frame,
  input  logic             frame_done,
  input  logic             sda_pin,
  input  logic             sda_drv,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             addr_hit,
  input  logic             gcall_hit,
  input  logic             tx_load,
  input  logic             tx_mode_sel,
  input  logic             start_gen,
  input  logic             slv_to_tx,
  input  logic             sync_tx_last,
  input  logic             sync_rx_last,
  input  logic             rx_copy,
  input  logic             rdr_rd,
  input  logic             tdr_wr,
  input  logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] set_vec,
  output logic [NFLAG-1:0] side_clr
);
  logic slave_rx;
  logic arb_lost;
  logic overrun;

  always_comb begin
    slave_rx = mode.i2c && !mode.master && !mode.tx;
    arb_lost = mode.master &&
               ((mode.tx && scl_rise && (sda_drv != sda_pin)) ||
                (start_det && sda_pin));
    overrun  = sync_rx_last && flags[B_RXFULL];

    set_vec           = '0;
    set_vec[B_GCALL]  = slave_rx && first_frame && gcall_hit;
    set_vec[B_ADDR]   = slave_rx && first_frame && addr_hit;
    set_vec[B_ARBOVR] = mode.i2c ? arb_lost : overrun;
    set_vec[B_STOP]   = mode.i2c && stop_det && frame_done;
    set_vec[B_NACK]   = mode.ack_chk && mode.tx && frame_end && sda_pin;
    set_vec[B_RXFULL] = rx_copy;
    set_vec[B_TXEND]  = mode.i2c ? (frame_end && flags[B_TXEMP]) : sync_tx_last;
    set_vec[B_TXEMP]  = tx_load || tx_mode_sel || start_gen || slv_to_tx;

    side_clr           = '0;
    side_clr[B_TXEMP]  = tdr_wr;
    side_clr[B_TXEND]  = tdr_wr;
    side_clr[B_RXFULL] = rdr_rd;
  end
endmodule

// File: rtl/sif_flag_bit.sv
module sif_flag_bit (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic side_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q
);
  logic q_d;
  logic armed_q, armed_d;
  logic clr_req;

  always_comb begin
    clr_req = wr_i && !wbit_i && armed_q;

    q_d = q;
    if (set_i)                      q_d = 1'b1;
    else if (clr_req || side_clr_i) q_d = 1'b0;

    armed_d = armed_q;
    if (wr_i)           armed_d = 1'b0;
    else if (rd_i && q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      q       <= q_d;
      armed_q <= armed_d;
    end
  end

  AST_WR_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && wbit_i && !set_i && !side_clr_i) |=> (q == $past(q))); // R2
  AST_CLR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (q && !armed_q && !set_i && !side_clr_i) |=> q); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> q); // R4
endmodule

// File: rtl/sif_status_unit.sv
module sif_status_unit
  import sif_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int ACK_EDGE = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i2c,
  input  logic             mode_master,
  input  logic             mode_tx,
  input  logic             ack_chk_en,
  input  logic             scl_rise,
  input  logic [CNT_W-1:0] bit_num,
  input  logic             sda_pin,
  input  logic             sda_drv,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             addr_hit,
  input  logic             gcall_hit,
  input  logic             tx_load,
  input  logic             tx_mode_sel,
  input  logic             start_gen,
  input  logic             slv_to_tx,
  input  logic             sync_tx_last,
  input  logic             sync_rx_last,
  input  logic             rx_copy,
  input  logic             st_rd,
  input  logic             st_wr,
  input  logic [7:0]       st_wdata,
  input  logic             rdr_rd,
  input  logic             tdr_wr,
  output logic [7:0]       st_rdata,
  output logic             xfer_halt
);
  logic             rst_ni;
  sif_mode_t        mode;
  logic             frame_end, first_frame, frame_done;
  logic [NFLAG-1:0] flags, set_vec, side_clr;

  always_comb begin
    mode.i2c     = mode_i2c;
    mode.master  = mode_master;
    mode.tx      = mode_tx;
    mode.ack_chk = ack_chk_en;
  end

  sif_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  sif_frame_track #(.CNT_W(CNT_W), .ACK_EDGE(ACK_EDGE)) u_frame (
    .clk(clk), .rst_ni(rst_ni), .i2c(mode_i2c), .scl_rise(scl_rise),
    .bit_num(bit_num), .start_det(start_det), .stop_det(stop_det),
    .sync_tx_last(sync_tx_last), .sync_rx_last(sync_rx_last),
    .frame_end(frame_end), .first_frame(first_frame), .frame_done(frame_done)
  );

  sif_event_decode u_dec (
    .mode(mode), .scl_rise(scl_rise), .frame_end(frame_end),
    .first_frame(first_frame), .frame_done(frame_done),
    .sda_pin(sda_pin), .sda_drv(sda_drv), .start_det(start_det),
    .stop_det(stop_det), .addr_hit(addr_hit), .gcall_hit(gcall_hit),
    .tx_load(tx_load), .tx_mode_sel(tx_mode_sel), .start_gen(start_gen),
    .slv_to_tx(slv_to_tx), .sync_tx_last(sync_tx_last),
    .sync_rx_last(sync_rx_last), .rx_copy(rx_copy), .rdr_rd(rdr_rd),
    .tdr_wr(tdr_wr), .flags(flags), .set_vec(set_vec), .side_clr(side_clr)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sif_flag_bit u_bit (
      .clk(clk), .rst_ni(rst_ni), .set_i(set_vec[i]), .side_clr_i(side_clr[i]),
      .rd_i(st_rd), .wr_i(st_wr), .wbit_i(st_wdata[i]), .q(flags[i])
    );
  end

  assign st_rdata  = flags;
  assign xfer_halt = flags[B_NACK] && ack_chk_en;

  AST_TDR_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    (tdr_wr && !(tx_load || tx_mode_sel || start_gen || slv_to_tx))
      |=> !st_rdata[B_TXEMP]); // R9
  AST_RDR_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    (rdr_rd && !rx_copy) |=> !st_rdata[B_RXFULL]); // R9
  AST_RXFULL_ON_COPY: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_copy |=> st_rdata[B_RXFULL]); // R13
  AST_NO_OVR_IN_I2C: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i2c && !mode_master && !st_rdata[B_ARBOVR] && !st_wr) |=> !st_rdata[B_ARBOVR]); // R6
endmodule

// File: tb/sif_status_unit_bench.sv
module sif_status_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i2c = 1'b1, mode_master = 1'b0, mode_tx = 1'b0, ack_chk_en = 1'b0;
  logic scl_rise = 1'b0;
  logic [3:0] bit_num = 4'd0;
  logic sda_pin = 1'b0, sda_drv = 1'b0;
  logic start_det = 1'b0, stop_det = 1'b0, addr_hit = 1'b0, gcall_hit = 1'b0;
  logic tx_load = 1'b0, tx_mode_sel = 1'b0, start_gen = 1'b0, slv_to_tx = 1'b0;
  logic sync_tx_last = 1'b0, sync_rx_last = 1'b0, rx_copy = 1'b0;
  logic st_rd = 1'b0, st_wr = 1'b0, rdr_rd = 1'b0, tdr_wr = 1'b0;
  logic [7:0] st_wdata = 8'h00;
  logic [7:0] st_rdata;
  logic xfer_halt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sif_status_unit u_sif_status_unit (.*);

  // ---------------- behavioural reference model ----------------
  int mf[8];
  int ma[8];
  int m_first, m_done, m_rcnt;

  always @(posedge clk) begin
    int s[8];
    int fe;
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt++;
      foreach (mf[i]) begin mf[i] = 0; ma[i] = 0; end
      m_first = 0; m_done = 0;
    end else begin
      fe = (mode_i2c && scl_rise && bit_num == 9) ? 1 : 0;
      foreach (s[i]) s[i] = 0;
      if (mode_i2c && !mode_master && !mode_tx && m_first != 0) begin
        s[0] = gcall_hit; s[1] = addr_hit;
      end
      if (mode_i2c)
        s[2] = (mode_master && ((mode_tx && scl_rise && sda_pin != sda_drv) || (start_det && sda_pin))) ? 1 : 0;
      else
        s[2] = (sync_rx_last && mf[5] != 0) ? 1 : 0;
      s[3] = (mode_i2c && stop_det && m_done != 0) ? 1 : 0;
      s[4] = (ack_chk_en && mode_tx && fe != 0 && sda_pin) ? 1 : 0;
      s[5] = rx_copy;
      s[6] = mode_i2c ? ((fe != 0 && mf[7] != 0) ? 1 : 0) : int'(sync_tx_last);
      s[7] = (tx_load || tx_mode_sel || start_gen || slv_to_tx) ? 1 : 0;
      for (int i = 0; i < 8; i++) begin
        int clr;
        clr = (st_wr && !st_wdata[i] && ma[i] != 0) ? 1 : 0;
        if ((i == 7 || i == 6) && tdr_wr) clr = 1;
        if (i == 5 && rdr_rd) clr = 1;
        if (st_wr) ma[i] = 0;
        else if (st_rd && mf[i] != 0) ma[i] = 1;
        if (s[i] != 0) mf[i] = 1;
        else if (clr != 0) mf[i] = 0;
      end
      if (start_det || stop_det) m_done = 0;
      else if (fe != 0 || sync_tx_last || sync_rx_last) m_done = 1;
      if (start_det) m_first = 1;
      else if (fe != 0) m_first = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp;
      for (int i = 0; i < 8; i++) exp[i] = (mf[i] != 0);
      n_chk++;
      if (st_rdata !== exp) begin
        n_fail++;
        $display("FAIL model R1-map: status got %02h expected %02h at %0t", st_rdata, exp, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(negedge clk);
    scl_rise = 0; start_det = 0; stop_det = 0; addr_hit = 0; gcall_hit = 0;
    tx_load = 0; tx_mode_sel = 0; start_gen = 0; slv_to_tx = 0;
    sync_tx_last = 0; sync_rx_last = 0; rx_copy = 0;
    st_rd = 0; st_wr = 0; rdr_rd = 0; tdr_wr = 0; st_wdata = 8'h00;
  endtask

  task automatic chk_bit(string req, int idx, logic exp);
    n_chk++;
    if (st_rdata[idx] !== exp) begin
      n_fail++;
      $display("FAIL %s: bit %0d got %0b expected %0b", req, idx, st_rdata[idx], exp);
    end
  endtask

  task automatic chk_word(string req, logic [7:0] exp);
    n_chk++;
    if (st_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: status got %02h expected %02h", req, st_rdata, exp);
    end
  endtask

  task automatic clear_all();
    st_rd = 1; tick();
    st_wr = 1; st_wdata = 8'h00; tick();
  endtask

  task automatic edge9(logic pin);
    scl_rise = 1; bit_num = 4'd9; sda_pin = pin; sda_drv = pin; tick();
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    chk_word("R1 reset", 8'h00);

    // R8 transmit-empty set events, R2/R3 clear protocol
    tx_mode_sel = 1; tick();
    chk_bit("R8 tx mode", 7, 1);
    st_wr = 1; st_wdata = 8'hFF; tick();
    chk_bit("R2 write 1", 7, 1);
    st_wr = 1; st_wdata = 8'h00; tick();
    chk_bit("R3 clear without read", 7, 1);
    st_rd = 1; tick();
    st_wr = 1; st_wdata = 8'h7F; tick();
    chk_bit("R3 clear after read", 7, 0);
    start_gen = 1; tick();
    chk_bit("R8 start generated", 7, 1);
    tdr_wr = 1; tick();
    chk_bit("R9 tdr write", 7, 0);
    slv_to_tx = 1; tick();
    chk_bit("R8 slave rx to tx", 7, 1);
    tdr_wr = 1; tick();
    tx_load = 1; tick();
    chk_bit("R8 tx load", 7, 1);
    // R3 a write discards read qualification
    st_rd = 1; tick();
    st_wr = 1; st_wdata = 8'hFF; tick();
    st_wr = 1; st_wdata = 8'h00; tick();
    chk_bit("R3 qualification dropped", 7, 1);

    // R7 transmit end, I2C
    edge9(1'b0);
    chk_bit("R7 ninth edge", 6, 1);
    tdr_wr = 1; tick();
    chk_word("R9 tdr clears both", 8'h00);
    edge9(1'b0);
    chk_bit("R7 no end when tx not empty", 6, 0);
    // R7 synchronous mode
    mode_i2c = 0;
    sync_tx_last = 1; tick();
    chk_bit("R7 sync last bit", 6, 1);
    clear_all();

    // R13 receive full, R9 read clears, R6 overrun
    rx_copy = 1; tick();
    chk_bit("R13 rx copy", 5, 1);
    rdr_rd = 1; tick();
    chk_bit("R9 rdr read", 5, 0);
    sync_rx_last = 1; tick();
    chk_bit("R6 no overrun when empty", 2, 0);
    rx_copy = 1; tick();
    sync_rx_last = 1; tick();
    chk_bit("R6 overrun", 2, 1);
    clear_all();
    mode_i2c = 1;
    rx_copy = 1; tick();
    sync_rx_last = 1; tick();
    chk_bit("R6 no overrun in I2C", 2, 0);
    clear_all();

    // R5 arbitration
    mode_master = 1; mode_tx = 1;
    scl_rise = 1; bit_num = 4'd3; sda_drv = 1; sda_pin = 0; tick();
    chk_bit("R5 sda mismatch", 2, 1);
    clear_all();
    scl_rise = 1; bit_num = 4'd3; sda_drv = 1; sda_pin = 1; tick();
    chk_bit("R5 sda match", 2, 0);
    mode_tx = 0; start_det = 1; sda_pin = 1; tick();
    chk_bit("R5 start with sda high", 2, 1);
    clear_all();

    // R10 no acknowledge
    mode_tx = 1; ack_chk_en = 1;
    edge9(1'b1);
    chk_bit("R10 nack", 4, 1);
    n_chk++;
    if (xfer_halt !== 1'b1) begin n_fail++; $display("FAIL R10 halt: got %0b expected 1", xfer_halt); end
    clear_all();
    ack_chk_en = 0;
    edge9(1'b1);
    chk_bit("R10 checking off", 4, 0);
    clear_all();

    // R11 address match / general call, slave receive
    mode_master = 0; mode_tx = 0;
    start_det = 1; sda_pin = 0; tick();
    addr_hit = 1; tick();
    chk_bit("R11 address match", 1, 1);
    gcall_hit = 1; tick();
    chk_bit("R11 general call", 0, 1);
    clear_all();
    edge9(1'b0);
    addr_hit = 1; gcall_hit = 1; tick();
    chk_word("R11 outside first frame", 8'h00);

    // R12 stop detection (a frame has passed: done above)
    stop_det = 1; tick();
    chk_bit("R12 stop after frame", 3, 1);
    clear_all();
    start_det = 1; tick();
    stop_det = 1; tick();
    chk_bit("R12 stop without frame", 3, 0);

    // R4 set wins over clear
    rx_copy = 1; tick();
    st_rd = 1; tick();
    st_wr = 1; st_wdata = 8'h00; rx_copy = 1; tick();
    chk_bit("R4 set vs write clear", 5, 1);
    rdr_rd = 1; rx_copy = 1; tick();
    chk_bit("R4 set vs read clear", 5, 1);
    clear_all();
    chk_word("R1 all clear", 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule